// File: doc/BRIEF.md
# Per-Line Programmable Input Debouncer

This block is a bank of debounce filters that sits in front of a group of interrupt lines. Each line arrives as a raw level that is already synchronized. A filtered line changes its output only after the raw level has held a new value for a programmed length of time. Time is measured in pulses of a slow tick input, and each tick stands for `TICK_US` microseconds. A line whose index is `DBN_LINES` or higher has no filter, and its raw level goes straight to the output.

Software sets up the filters through a small control space. Each filtered line owns one byte, and four bytes share one 32-bit word. The space has three windows: a read window, a window where writing a one sets a bit, and a window where writing a one clears a bit. Each byte holds three things:
- an enable bit;
- a restart strobe that clears itself;
- a 4-bit index into a fixed table of stable times.

To reconfigure a line, software clears the whole byte and then sets the new index, the enable and the restart in a single write.

Top module: `line_debounce_bank`

## Requirements
- R1: After reset, every control byte reads zero and every output equals its raw input.
- R2: The control byte of line n is in word n/4 of the read window (byte address 0x500 + 4*(n/4)), at bits [(n%4)*8+7:(n%4)*8]. In that byte, bit 0 is the enable, bit 1 is the restart and bits [7:4] are the time index.
- R3: A write to 0x600 + 4*w ORs the enable and index bits into word w. A write to 0x700 + 4*w clears every bit written as one. The restart bit and byte bits [3:2] are never stored and always read zero.
- R4: Writes to the read window (0x500 to 0x5FF) have no effect on any control byte.
- R5: A line is active when its enable is set and its index is valid. On an active line the output takes a new raw value on the tick that completes N ticks of continuous difference. N is 1, 2, 4, 8, 128, 256, 512, 1024, 2048 or 4096 for index 0 to 9 (with `TICK_US`=125).
- R6: On an active line, any cycle in which the raw input equals the output restarts the count from zero.
- R7: Writing a one to the restart bit through the set window restarts the line's count within two clock cycles and leaves its output unchanged.
- R8: When a line's enable is clear, its output equals its raw input in the same cycle.
- R9: Lines at index `DBN_LINES` and above pass the raw input straight through. Their control bytes read zero, and writes to those bytes have no effect.
- R10: A line with its enable set and an index of 10 to 15 behaves as if the enable were clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | One-cycle pulse of the slow time base |
| raw_i | input | NUM_LINES | Synchronized raw line levels |
| wr_en_i | input | 1 | Control write strobe |
| wr_addr_i | input | 12 | Control write byte address |
| wr_data_i | input | 32 | Control write data |
| rd_addr_i | input | 12 | Control read byte address |
| rd_data_o | output | 32 | Control read data (combinational) |
| filt_o | output | NUM_LINES | Filtered line levels |

## Verification
A count that is kept too long or cleared too early moves the edge of the filtered output by at least one tick. The bench catches this by sampling the output just before and just after the tick that should complete the window. If the restart does not clear the count, the output toggles one full window early. If it clears the output as well, the output flips back on the next cycle. If a set, clear or read-window write lands in the wrong byte, the readback shows it at once, and the output of the wrongly enabled line shows it on its next edge.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
  localparam int ADDR_W   = 12;
  localparam int TBL_LEN  = 10;
  localparam int MAX_US   = 512000;
  localparam logic [3:0] REGION_READ = 4'h5;
  localparam logic [3:0] REGION_SET  = 4'h6;
  localparam logic [3:0] REGION_CLR  = 4'h7;
  localparam logic [7:0] STORE_MASK  = 8'hF1;

  // Stable time in microseconds for each index of the ordered table.
  function automatic int stable_us(input logic [3:0] idx);
    case (idx)
      4'd0:    return 125;
      4'd1:    return 250;
      4'd2:    return 500;
      4'd3:    return 1000;
      4'd4:    return 16000;
      4'd5:    return 32000;
      4'd6:    return 64000;
      4'd7:    return 128000;
      4'd8:    return 256000;
      4'd9:    return 512000;
      default: return 0;
    endcase
  endfunction

  // Number of ticks a difference must last, never less than one.
  function automatic int stable_ticks(input logic [3:0] idx, input int tick_us);
    int t;
    t = stable_us(idx) / tick_us;
    return (t < 1) ? 1 : t;
  endfunction
endpackage

// File: rtl/dbn_regs.sv
module dbn_regs #(
  parameter int DBN_LINES = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [dbn_pkg::ADDR_W-1:0]    wr_addr_i,
  input  logic [31:0]                   wr_data_i,
  input  logic [dbn_pkg::ADDR_W-1:0]    rd_addr_i,
  output logic [31:0]                   rd_data_o,
  output logic [DBN_LINES-1:0]          en_o,
  output logic [DBN_LINES*4-1:0]        idx_o,
  output logic [DBN_LINES-1:0]          restart_o
);
  import dbn_pkg::*;

  localparam int NWORDS = (DBN_LINES + 3) / 4;
  localparam int WORD_W = 6;

  logic [7:0]             fld_q   [DBN_LINES];
  logic [7:0]             fld_d   [DBN_LINES];
  logic [DBN_LINES-1:0]   restart_q, restart_d;
  logic [DBN_LINES*8-1:0] fld_flat;

  logic [3:0]        wr_region, rd_region;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic              wr_aligned, rd_aligned;
  logic              set_hit, clr_hit;

  assign wr_region  = wr_addr_i[ADDR_W-1:8];
  assign wr_word    = wr_addr_i[7:2];
  assign wr_aligned = (wr_addr_i[1:0] == 2'b00);
  assign rd_region  = rd_addr_i[ADDR_W-1:8];
  assign rd_word    = rd_addr_i[7:2];
  assign rd_aligned = (rd_addr_i[1:0] == 2'b00);

  assign set_hit = wr_en_i && wr_aligned && (wr_region == REGION_SET);
  assign clr_hit = wr_en_i && wr_aligned && (wr_region == REGION_CLR);

  // Next-state for stored bytes and restart strobes
  always_comb begin
    for (int l = 0; l < DBN_LINES; l++) begin
      logic [7:0] wbyte;
      logic       sel;
      wbyte        = wr_data_i[(l % 4) * 8 +: 8];
      sel          = (int'(wr_word) == (l / 4));
      fld_d[l]     = fld_q[l];
      restart_d[l] = 1'b0;
      if (set_hit && sel) begin
        fld_d[l]     = fld_q[l] | (wbyte & STORE_MASK);
        restart_d[l] = wbyte[1];
      end else if (clr_hit && sel) begin
        fld_d[l]     = fld_q[l] & ~wbyte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < DBN_LINES; l++) fld_q[l] <= '0;
      restart_q <= '0;
    end else begin
      for (int l = 0; l < DBN_LINES; l++) fld_q[l] <= fld_d[l];
      restart_q <= restart_d;
    end
  end

  // Read view assembly
  always_comb begin
    rd_data_o = '0;
    if (rd_aligned && (rd_region == REGION_READ) && (int'(rd_word) < NWORDS)) begin
      for (int l = 0; l < DBN_LINES; l++) begin
        if (int'(rd_word) == (l / 4)) rd_data_o[(l % 4) * 8 +: 8] = fld_q[l];
      end
    end
  end

  generate
    for (genvar l = 0; l < DBN_LINES; l++) begin : g_out
      assign en_o[l]          = fld_q[l][0];
      assign idx_o[l*4 +: 4]  = fld_q[l][7:4];
      assign fld_flat[l*8 +: 8] = fld_q[l];
    end
  endgenerate
  assign restart_o = restart_q;

  // R4: a write into the read window changes no stored byte
  a_r4_readview_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (wr_region == REGION_READ)) |=> $stable(fld_flat));

  // R3: a restart strobe only follows a write
  a_r3_restart_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|restart_q) |-> $past(wr_en_i));

  // R3: bits [3:1] of every stored byte stay zero
  a_r3_unstored_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_flat & {DBN_LINES{8'h0E}}) == '0);
endmodule

// File: rtl/dbn_filter.sv
module dbn_filter #(
  parameter int TICK_US = 125,
  parameter int CNT_W   = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_i,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic [3:0] idx_i,
  input  logic       restart_i,
  output logic       filt_o
);
  import dbn_pkg::*;

  logic             active;
  int               limit;
  logic             out_q, out_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign active = en_i && (int'(idx_i) < TBL_LEN);
  assign limit  = stable_ticks(idx_i, TICK_US);

  always_comb begin
    out_d = out_q;
    cnt_d = cnt_q;
    if (!active) begin
      out_d = raw_i;
      cnt_d = '0;
    end else if (restart_i) begin
      cnt_d = '0;
    end else if (raw_i == out_q) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (int'(cnt_q) + 1 >= limit) begin
        out_d = raw_i;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign filt_o = active ? out_q : raw_i;

  a_r7_restart_keeps_out: assert property (@(posedge clk) disable iff (!rst_n)
    (active && restart_i) |=> $stable(out_q));

  a_r5_no_tick_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick_i) |=> $stable(out_q));

  a_r6_match_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (raw_i == out_q)) |=> (cnt_q == '0));

  a_r8_idle_tracks_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (!active) |=> (out_q == $past(raw_i)));
endmodule

// File: rtl/line_debounce_bank.sv
module line_debounce_bank #(
  parameter int NUM_LINES = 8,
  parameter int DBN_LINES = 6,
  parameter int TICK_US   = 125
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_i,
  input  logic [NUM_LINES-1:0]       raw_i,
  input  logic                       wr_en_i,
  input  logic [dbn_pkg::ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]                wr_data_i,
  input  logic [dbn_pkg::ADDR_W-1:0] rd_addr_i,
  output logic [31:0]                rd_data_o,
  output logic [NUM_LINES-1:0]       filt_o
);
  localparam int MAX_TICKS = dbn_pkg::MAX_US / TICK_US;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [1:0]           rst_sync_q;
  logic                 rst_core_n;
  logic [DBN_LINES-1:0]   en_w, restart_w;
  logic [DBN_LINES*4-1:0] idx_w;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  dbn_regs #(.DBN_LINES(DBN_LINES)) regs_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .en_o      (en_w),
    .idx_o     (idx_w),
    .restart_o (restart_w)
  );

  generate
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      if (l < DBN_LINES) begin : g_filt
        dbn_filter #(.TICK_US(TICK_US), .CNT_W(CNT_W)) filt_i (
          .clk       (clk),
          .rst_n     (rst_core_n),
          .raw_i     (raw_i[l]),
          .tick_i    (tick_i),
          .en_i      (en_w[l]),
          .idx_i     (idx_w[l*4 +: 4]),
          .restart_i (restart_w[l]),
          .filt_o    (filt_o[l])
        );
      end else begin : g_pass
        assign filt_o[l] = raw_i[l];
      end
    end
  endgenerate
endmodule

// File: tb/line_debounce_bank_tb_top.sv
module line_debounce_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i;
  logic [NL-1:0] raw_i;
  logic        wr_en_i;
  logic [11:0] wr_addr_i, rd_addr_i;
  logic [31:0] wr_data_i, rd_data_o;
  logic [NL-1:0] filt_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    bit          is_read;
    int          line;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  line_debounce_bank #(.NUM_LINES(NL), .DBN_LINES(6), .TICK_US(125)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .raw_i(raw_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .filt_o(filt_o));

  // Monitor: pops expected items and compares shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_read ? rd_data_o : {31'b0, filt_o[it.line]};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic exp_line(input int line, input logic v, input string tag);
    item_t it;
    it.is_read = 0; it.line = line; it.exp = {31'b0, v}; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic exp_read(input logic [11:0] a, input logic [31:0] v, input string tag);
    item_t it;
    rd_addr_i = a;
    it.is_read = 1; it.line = 0; it.exp = v; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1;
      @(negedge clk);
      tick_i = 0;
      @(negedge clk);
    end
  endtask

  task automatic set_raw(input int line, input logic v);
    raw_i[line] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick_i = 0; raw_i = 8'hA5; wr_en_i = 0;
    wr_addr_i = '0; wr_data_i = '0; rd_addr_i = 12'h500;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    exp_read(12'h500, 32'h0, "R1 word0 after reset");
    exp_read(12'h504, 32'h0, "R1 word1 after reset");
    for (int l = 0; l < NL; l++) exp_line(l, raw_i[l], "R1 output follows raw after reset");

    // R2/R3: line0 idx0 en (+rsvd bits), line1 idx1 en + restart
    wr(12'h600, 32'h0000_130D);
    exp_read(12'h500, 32'h0000_1101, "R2 R3 set window layout");
    // R9: bytes beyond last filtered line stay zero
    wr(12'h604, 32'hFFFF_0031);
    exp_read(12'h504, 32'h0000_0031, "R9 unfiltered bytes read zero");
    // R4: write into read window ignored
    wr(12'h500, 32'hFFFF_FFFF);
    exp_read(12'h500, 32'h0000_1101, "R4 read window write ignored");

    // R5: line0 index 0 -> 1 tick
    set_raw(0, 0);
    exp_line(0, 1'b1, "R5 idx0 before tick");
    ticks(1);
    exp_line(0, 1'b0, "R5 idx0 after 1 tick");

    // R5: line1 index 1 -> 2 ticks
    set_raw(1, 1);
    ticks(1);
    exp_line(1, 1'b0, "R5 idx1 after 1 tick");
    ticks(1);
    exp_line(1, 1'b1, "R5 idx1 after 2 ticks");

    // R6: line4 index 3 -> 8 ticks, bounce restarts
    set_raw(4, 1);
    ticks(5);
    exp_line(4, 1'b0, "R6 before bounce");
    set_raw(4, 0);
    @(negedge clk);
    set_raw(4, 1);
    ticks(7);
    exp_line(4, 1'b0, "R6 seven ticks after bounce");
    ticks(1);
    exp_line(4, 1'b1, "R6 eight ticks after bounce");

    // R7: restart keeps output, restarts count
    set_raw(4, 0);
    ticks(7);
    exp_line(4, 1'b1, "R7 before restart");
    wr(12'h604, 32'h0000_0002);
    exp_line(4, 1'b1, "R7 output kept after restart");
    exp_read(12'h504, 32'h0000_0031, "R7 restart bit not stored");
    ticks(7);
    exp_line(4, 1'b1, "R7 seven ticks after restart");
    ticks(1);
    exp_line(4, 1'b0, "R7 eight ticks after restart");

    // R10: reconfigure line0 to invalid index 10
    wr(12'h700, 32'h0000_00FF);
    wr(12'h600, 32'h0000_00A3);
    exp_read(12'h500, 32'h0000_11A1, "R10 reconfigured byte");
    set_raw(0, 1);
    exp_line(0, 1'b1, "R10 invalid index passes raw");
    set_raw(0, 0);
    exp_line(0, 1'b0, "R10 invalid index passes raw low");

    // R8: clear enable on line1
    wr(12'h700, 32'h0000_0100);
    exp_read(12'h500, 32'h0000_10A1, "R8 enable cleared");
    set_raw(1, 0);
    exp_line(1, 1'b0, "R8 disabled follows raw");
    set_raw(1, 1);
    exp_line(1, 1'b1, "R8 disabled follows raw high");

    // R9: pass-through line 6
    set_raw(6, 1);
    exp_line(6, 1'b1, "R9 bypass line high");
    set_raw(6, 0);
    exp_line(6, 1'b0, "R9 bypass line low");

    // R5: line0 index 2 -> 4 ticks
    wr(12'h700, 32'h0000_00FF);
    wr(12'h600, 32'h0000_0023);
    set_raw(0, 1);
    ticks(3);
    exp_line(0, 1'b0, "R5 idx2 after 3 ticks");
    ticks(1);
    exp_line(0, 1'b1, "R5 idx2 after 4 ticks");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule